// File: doc/BRIEF.md
# Protected Oscillator Rate Changeover Sequencer

This block controls when a dual-rate high-frequency oscillator moves between its slow and fast settings. Software reaches it through a small register bus. The configuration register that holds the rate-select bit is guarded by a fixed 16-bit key. A configuration write is accepted only when the key was written immediately before it.

An accepted change does not simply flip the select bit. The block first gates the downstream clock off. One cycle later it changes the select bit. It then waits until the oscillator reports ready for a set number of consecutive cycles, and only then opens the gate again. A move to the fast setting is refused unless the downstream divider input holds the value that keeps the clock sent to the neighbouring domain at the slow rate. Refused and unauthorised writes raise sticky error flags, which software clears by writing ones to them.

Register map: address 0 holds the configuration, with the rate-select bit at bit 2. Address 1 takes the key. Address 3 clears the error flags by writing ones to them.

Top module: `osc_switch_seq`

## Requirements
- R1: After reset, `clk_gate_en` is 1, `freq_sel` is 1 (slow rate), and `busy`, `key_err` and `div_err` are all 0.
- R2: Writing 16'hA5C3 to address 1 unlocks exactly the next bus write. A write to address 0 made while unlocked is accepted, where data bit 2 = 0 requests the fast rate and bit 2 = 1 requests the slow rate.
- R3: Any write after the key other than the configuration write relocks the register, so a later configuration write is ignored. This covers a write to address 2, a write to address 3, or a write of a wrong value to address 1.
- R4: A write to address 0 while locked leaves `freq_sel`, `busy` and `clk_gate_en` unchanged and sets `key_err`.
- R5: Writing to address 3 with data bit 0 = 1 clears `key_err`, and with data bit 1 = 1 clears `div_err`. A 0 in either bit leaves that flag as it is, and no key is needed.
- R6: For an accepted change, `clk_gate_en` goes low in the cycle after the write edge, `freq_sel` takes its new value one cycle later, and `clk_gate_en` rises only after `osc_ready` has been sampled high on 8 consecutive edges.
- R7: If `osc_ready` is low on any sampled edge while the block is settling, the consecutive count starts again, and the gate stays closed until 8 further consecutive high samples have been seen.
- R8: A request for the fast rate while `div_setting` is not 2 is refused: `freq_sel`, `busy` and `clk_gate_en` do not change, and `div_err` is set.
- R9: `busy` is high from the cycle the gate closes until the cycle it reopens. An unlocked configuration write made while `busy` is high has no effect on the sequence or on the final `freq_sel`.
- R10: Changes work in both directions, and a move to the slow rate is carried out whatever `div_setting` holds.
- R11: An accepted configuration write that requests the rate already selected starts no sequence, so `busy` stays low and the gate stays open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| div_setting | input | 6 | Current downstream divider setting |
| osc_ready | input | 1 | Oscillator reports a stable output |
| clk_gate_en | output | 1 | Downstream clock gate enable |
| freq_sel | output | 1 | Rate select to the oscillator, 0 = fast, 1 = slow |
| busy | output | 1 | Changeover sequence in progress |
| key_err | output | 1 | Sticky flag for an unauthorised configuration write |
| div_err | output | 1 | Sticky flag for a refused fast-rate request |

## Verification
The assertions watch the ordering rules on every cycle. The select bit may only move while the gate is closed, the gate may only reopen at the end of a busy period, and an idle block keeps the gate open. A fast-rate start must have seen a divider of 2, a low ready sample keeps the block settling, and the target is frozen while busy. The assertions also require that `key_err` rises only after a configuration write. What they cannot show is the exact cycle of each step, the single-write scope of an unlock, the relocking effect of each kind of intervening write, and the write-one-to-clear behaviour of the flags. The directed scenarios in the bench cover these at the ports.

// File: rtl/osc_switch_pkg.sv
// Package: shared constants and state encoding for the oscillator
// changeover sequencer. Assumes a single clock and a small register map.
package osc_switch_pkg;
    localparam int unsigned CFG_ADDR  = 0;
    localparam int unsigned KEY_ADDR  = 1;
    localparam int unsigned FLAG_ADDR = 3;
    localparam int unsigned SEL_BIT   = 2;
    localparam logic        SEL_FAST  = 1'b0;
    localparam logic        SEL_SLOW  = 1'b1;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_GATE_OFF = 2'd1,
        ST_SETTLE   = 2'd2
    } sw_state_t;
endpackage

// File: rtl/osc_key_guard.sv
// Module: key guard for the configuration register. A correct key write
// arms the guard for the next bus write only; every write re-evaluates it.
// Assumes bus_wr is a single-cycle strobe per write.
module osc_key_guard
    import osc_switch_pkg::*;
#(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned DATA_W  = 16,
    parameter logic [15:0] KEY_VAL = 16'hA5C3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    output logic              cfg_accept,
    output logic              cfg_reject
);
    logic armed;
    logic cfg_hit;

    // Purpose: decode a configuration write and split it by lock state.
    always_comb begin
        cfg_hit    = bus_wr && (bus_addr == ADDR_W'(CFG_ADDR));
        cfg_accept = cfg_hit && armed;
        cfg_reject = cfg_hit && !armed;
    end

    // Purpose: arm on a correct key write, disarm on any other write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (bus_wr) begin
            armed <= (bus_addr == ADDR_W'(KEY_ADDR)) && (bus_wdata == DATA_W'(KEY_VAL));
        end
    end

    // An unlock never survives a write that is not itself the key.
    assert_unlock_single_use_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != ADDR_W'(KEY_ADDR)) |=> !armed);
endmodule

// File: rtl/osc_err_flags.sv
// Module: sticky error flags with write-one-to-clear. A set pulse wins over
// a clear in the same cycle. Assumes flag i is cleared by data bit i.
module osc_err_flags #(
    parameter int unsigned NFLAG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_pulse,
    input  logic             clr_wr,
    input  logic [NFLAG-1:0] clr_bits,
    output logic [NFLAG-1:0] flags
);
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        // Purpose: hold one sticky flag until software clears it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else if (set_pulse[i]) begin
                flags[i] <= 1'b1;
            end else if (clr_wr && clr_bits[i]) begin
                flags[i] <= 1'b0;
            end
        end

        assert_flag_rise_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[i]) |-> $past(set_pulse[i]));
    end
endmodule

// File: rtl/osc_switch_fsm.sv
// Module: changeover sequencer. Closes the gate, moves the select bit,
// waits for SETTLE_CYCLES consecutive ready samples, then reopens the gate.
// Fast-rate requests are checked against the required divider value.
// Assumes requests arrive as single-cycle accept pulses.
module osc_switch_fsm
    import osc_switch_pkg::*;
#(
    parameter int unsigned DIV_W         = 6,
    parameter int unsigned REQ_DIV       = 2,
    parameter int unsigned SETTLE_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_sel,
    input  logic [DIV_W-1:0] div_setting,
    input  logic             osc_ready,
    output logic             clk_gate_en,
    output logic             freq_sel,
    output logic             busy,
    output logic             div_fault
);
    localparam int unsigned CNT_W = (SETTLE_CYCLES > 2) ? $clog2(SETTLE_CYCLES) : 1;

    sw_state_t        state;
    logic             target;
    logic [CNT_W-1:0] ready_cnt;
    logic             want_change;
    logic             div_ok;

    // Purpose: classify an incoming request while idle.
    always_comb begin
        want_change = req_valid && (state == ST_IDLE) && (req_sel != freq_sel);
        div_ok      = (req_sel == SEL_SLOW) || (div_setting == DIV_W'(REQ_DIV));
        div_fault   = want_change && !div_ok;
        busy        = (state != ST_IDLE);
    end

    // Purpose: step through gate-off, switch and settle, then gate-on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            target      <= SEL_SLOW;
            freq_sel    <= SEL_SLOW;
            clk_gate_en <= 1'b1;
            ready_cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (want_change && div_ok) begin
                        target      <= req_sel;
                        clk_gate_en <= 1'b0;
                        state       <= ST_GATE_OFF;
                    end
                end
                ST_GATE_OFF: begin
                    freq_sel  <= target;
                    ready_cnt <= '0;
                    state     <= ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (!osc_ready) begin
                        ready_cnt <= '0;
                    end else if (ready_cnt == CNT_W'(SETTLE_CYCLES - 1)) begin
                        clk_gate_en <= 1'b1;
                        state       <= ST_IDLE;
                    end else begin
                        ready_cnt <= ready_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_fast_start_needs_div_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && target == SEL_FAST) |-> $past(div_setting) == DIV_W'(REQ_DIV));

    assert_low_ready_keeps_settling_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE && !osc_ready) |=> (state == ST_SETTLE));

    assert_target_frozen_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(target));
endmodule

// File: rtl/osc_switch_seq.sv
// Module: top of the protected oscillator changeover sequencer. Connects the
// key guard, the sequencer and the sticky error flags to the register bus.
// Assumes one write per bus_wr pulse and that div_setting is synchronous.
module osc_switch_seq
    import osc_switch_pkg::*;
#(
    parameter int unsigned ADDR_W        = 4,
    parameter int unsigned DATA_W        = 16,
    parameter int unsigned DIV_W         = 6,
    parameter int unsigned REQ_DIV       = 2,
    parameter int unsigned SETTLE_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic [DIV_W-1:0]  div_setting,
    input  logic              osc_ready,
    output logic              clk_gate_en,
    output logic              freq_sel,
    output logic              busy,
    output logic              key_err,
    output logic              div_err
);
    localparam int unsigned NFLAG = 2;

    logic             cfg_accept;
    logic             cfg_reject;
    logic             div_fault;
    logic             flag_wr;
    logic [NFLAG-1:0] flag_set;
    logic [NFLAG-1:0] flag_q;

    osc_key_guard #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_wr     (bus_wr),
        .cfg_accept (cfg_accept),
        .cfg_reject (cfg_reject)
    );

    osc_switch_fsm #(
        .DIV_W         (DIV_W),
        .REQ_DIV       (REQ_DIV),
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (cfg_accept),
        .req_sel     (bus_wdata[SEL_BIT]),
        .div_setting (div_setting),
        .osc_ready   (osc_ready),
        .clk_gate_en (clk_gate_en),
        .freq_sel    (freq_sel),
        .busy        (busy),
        .div_fault   (div_fault)
    );

    // Purpose: route set pulses and the clear write to the flag bank.
    always_comb begin
        flag_wr  = bus_wr && (bus_addr == ADDR_W'(FLAG_ADDR));
        flag_set = {div_fault, cfg_reject};
    end

    osc_err_flags #(
        .NFLAG (NFLAG)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (flag_set),
        .clr_wr    (flag_wr),
        .clr_bits  (bus_wdata[NFLAG-1:0]),
        .flags     (flag_q)
    );

    assign key_err = flag_q[0];
    assign div_err = flag_q[1];

    assert_sel_moves_only_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(freq_sel) |-> !clk_gate_en);

    assert_gate_reopens_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_gate_en) |-> $past(busy));

    assert_idle_gate_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> clk_gate_en);

    assert_key_err_after_cfg_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_err) |-> $past(bus_wr && bus_addr == ADDR_W'(CFG_ADDR)));
endmodule

// File: tb/osc_switch_seq_test.sv
module osc_switch_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] KEY = 16'hA5C3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic [5:0]  div_setting = 6'd2;
    logic        osc_ready = 1'b1;
    logic        clk_gate_en, freq_sel, busy, key_err, div_err;

    int checks = 0;
    int failures = 0;

    osc_switch_seq uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .div_setting(div_setting), .osc_ready(osc_ready),
        .clk_gate_en(clk_gate_en), .freq_sel(freq_sel), .busy(busy),
        .key_err(key_err), .div_err(div_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 gate", clk_gate_en, 1);
        check("R1 sel", freq_sel, 1);
        check("R1 busy", busy, 0);
        check("R1 key_err", key_err, 0);
        check("R1 div_err", div_err, 0);
    endtask

    task automatic t_locked_write();
        bus_write(4'd0, 16'h0000);
        check("R4 busy", busy, 0);
        check("R4 gate", clk_gate_en, 1);
        check("R4 key_err", key_err, 1);
        wait_cycles(1);
        check("R4 sel", freq_sel, 1);
        bus_write(4'd3, 16'h0002);
        check("R5 zero bit keeps key_err", key_err, 1);
        bus_write(4'd3, 16'h0001);
        check("R5 clear key_err", key_err, 0);
    endtask

    task automatic t_relock();
        bus_write(4'd1, KEY);
        bus_write(4'd2, 16'h0000);
        bus_write(4'd0, 16'h0000);
        check("R3 addr2 relocks busy", busy, 0);
        check("R3 addr2 relocks key_err", key_err, 1);
        bus_write(4'd3, 16'h0001);
        bus_write(4'd1, KEY ^ 16'h0001);
        bus_write(4'd0, 16'h0000);
        check("R3 wrong key busy", busy, 0);
        check("R3 wrong key key_err", key_err, 1);
        bus_write(4'd1, KEY);
        bus_write(4'd3, 16'h0001);
        check("R5 clear without key", key_err, 0);
        bus_write(4'd0, 16'h0000);
        check("R3 flag write relocks", key_err, 1);
        check("R3 flag write relocks busy", busy, 0);
        bus_write(4'd3, 16'h0001);
    endtask

    task automatic t_div_refuse();
        div_setting = 6'd4;
        bus_write(4'd1, KEY);
        bus_write(4'd0, 16'h0000);
        check("R8 div_err", div_err, 1);
        check("R8 busy", busy, 0);
        check("R8 gate", clk_gate_en, 1);
        check("R2 accepted write no key_err", key_err, 0);
        wait_cycles(2);
        check("R8 sel", freq_sel, 1);
        bus_write(4'd3, 16'h0001);
        check("R5 bit0 leaves div_err", div_err, 1);
        bus_write(4'd3, 16'h0002);
        check("R5 clear div_err", div_err, 0);
        div_setting = 6'd2;
    endtask

    task automatic t_switch_up();
        osc_ready = 1'b1;
        bus_write(4'd1, KEY);
        bus_write(4'd0, 16'h0000);
        check("R6 gate off first", clk_gate_en, 0);
        check("R6 sel not yet", freq_sel, 1);
        check("R9 busy at gate off", busy, 1);
        wait_cycles(1);
        check("R6 sel moved", freq_sel, 0);
        wait_cycles(7);
        check("R6 gate still off", clk_gate_en, 0);
        check("R9 busy held", busy, 1);
        wait_cycles(1);
        check("R6 gate on after 8", clk_gate_en, 1);
        check("R9 busy drops", busy, 0);
        check("R10 up to fast", freq_sel, 0);
        check("R2 no key_err", key_err, 0);
    endtask

    task automatic t_switch_down_glitch();
        div_setting = 6'd5;
        osc_ready = 1'b0;
        bus_write(4'd1, KEY);
        bus_write(4'd0, 16'h0004);
        check("R10 down ignores divider", busy, 1);
        check("R10 div_err clear", div_err, 0);
        wait_cycles(1);
        check("R10 sel slow", freq_sel, 1);
        div_setting = 6'd2;
        bus_write(4'd1, KEY);
        bus_write(4'd0, 16'h0000);
        wait_cycles(12);
        check("R7 no ready gate off", clk_gate_en, 0);
        osc_ready = 1'b1;
        wait_cycles(4);
        osc_ready = 1'b0;
        wait_cycles(1);
        osc_ready = 1'b1;
        wait_cycles(7);
        check("R7 restart gate off", clk_gate_en, 0);
        wait_cycles(1);
        check("R7 gate on", clk_gate_en, 1);
        check("R9 busy request ignored", freq_sel, 1);
        wait_cycles(3);
        check("R9 no late sequence", busy, 0);
        check("R9 no div_err", div_err, 0);
    endtask

    task automatic t_same_sel();
        bus_write(4'd1, KEY);
        bus_write(4'd0, 16'h0004);
        check("R11 busy", busy, 0);
        check("R11 gate", clk_gate_en, 1);
        check("R11 key_err", key_err, 0);
        wait_cycles(2);
        check("R11 sel", freq_sel, 1);
    endtask

    initial begin
        wait_cycles(3);
        rst_n = 1'b1;
        wait_cycles(1);
        t_reset();
        t_locked_write();
        t_relock();
        t_div_refuse();
        t_switch_up();
        t_switch_down_glitch();
        t_same_sel();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule